// File: doc/BRIEF.md
# Bidirectional Multi-Lane Column Driver Shift-Latch

This block is the logic core of a 96-output column driver. Display data enters as parallel words and moves through a 96-stage shift chain. The chain is split into interleaved lanes. Either 3 lanes of 32 stages or 6 lanes of 16 stages can be selected, and the chain can shift in either direction. Each end of the chain has a port. The direction input decides which end accepts new words and which end passes the oldest stages on to the next driver in a cascade. The end ports are modelled as separate input, output and output-enable signals.

A strobe copies the whole chain into a holding latch, so the drive outputs stay steady while the next line is shifted in. A combinational output stage then applies tri-state, blanking and polarity, in that order of priority. All logic runs on one system clock. The shift clock and the latch strobe are sampled inputs. A shift happens on each detected falling edge of the shift clock, and a capture happens on each detected rising edge of the strobe. Both take effect at the system clock edge that first sees the new level. Reset is synchronous and active high.

Top module: `colshift_top`

## Requirements
- R1: While `rst` is high at a clock edge, the chain and the latch clear to zero. After reset, with `hiz`=0, `blank`=0 and `pol`=1, `drv_data` reads all zeros with `drv_drive`=1, and both end-port outputs read zero.
- R2: The chain shifts exactly once for each high-to-low transition of `shclk`. A rising transition, or a level held for any number of clocks, leaves every stage unchanged.
- R3: With `dir`=1, port A is the input. Stage index i (0-based) takes stage i-w, where w is the lane count. Stages 0..w-1 take `a_in[w-1:0]`, with bit k going to stage k. `b_out[k]` presents stage 96-w+k. Whatever is on `b_in` has no effect.
- R4: With `dir`=0, port B is the input. Stage i takes stage i+w. Stages 96-w..95 take `b_in[w-1:0]`, with bit k going to stage 96-w+k. `a_out[k]` presents stage k. Whatever is on `a_in` has no effect.
- R5: `lane_sel`=1 selects 3 lanes (w=3, 32 stages per lane) and `lane_sel`=0 selects 6 lanes (w=6, 16 stages). A word entering at one end shows at the far port after exactly 32 or 16 shifts respectively.
- R6: With `lane_sel`=1, output bits 5..3 of both ports read zero, and input bits 5..3 are ignored.
- R7: `a_oe`=1 exactly when `dir`=0 and `b_oe`=1 exactly when `dir`=1. The output of the port that is not driving reads zero.
- R8: A low-to-high transition of `ld` copies all 96 stages into the latch. Otherwise the latch holds, even while `ld` stays high or the chain shifts.
- R9: With `hiz`=1, `drv_drive`=0 and `drv_data` is all zeros, whatever `blank` and `pol` are.
- R10: With `hiz`=0 and `blank`=1, every bit of `drv_data` equals `pol`.
- R11: With `hiz`=0 and `blank`=0, `drv_data[i]` equals latch bit i when `pol`=1 and its inverse when `pol`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shclk | input | 1 | Shift clock; each falling transition shifts once |
| dir | input | 1 | 1: A-to-B shifting, 0: B-to-A shifting |
| lane_sel | input | 1 | 1: 3 lanes of 32, 0: 6 lanes of 16 |
| a_in | input | 6 | A-end input word |
| a_out | output | 6 | A-end cascade output |
| a_oe | output | 1 | A-end is driving |
| b_in | input | 6 | B-end input word |
| b_out | output | 6 | B-end cascade output |
| b_oe | output | 1 | B-end is driving |
| ld | input | 1 | Latch strobe; rising transition captures the chain |
| blank | input | 1 | Force every output to the polarity level |
| pol | input | 1 | 1: true data, 0: inverted data |
| hiz | input | 1 | Release all outputs (high impedance) |
| drv_data | output | 96 | Column output levels |
| drv_drive | output | 1 | Column outputs actively driven |

## Verification
The bench pushes a single word through an otherwise empty chain in both lane modes. It checks that the word is absent one shift early and present exactly on shift 32 or 16. A lane-stride error makes the word arrive too soon or too late.

Each direction is run with garbage on the idle port and on the spare bits 5..3 in 3-lane mode. A design that mixed the wrong port or the wrong bits into the chain fails the bit-by-bit model compare. Holding `shclk` high or low, and holding `ld` high across shifts, exposes a design that acts on levels instead of transitions. Walking all eight tri-state, blank and polarity combinations catches a swapped priority or an inverted polarity sense.

// File: rtl/colshift_pkg.sv
package colshift_pkg;

    typedef enum logic {
        DIR_FROM_B = 1'b0,
        DIR_FROM_A = 1'b1
    } shift_dir_e;

    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_NARROW = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic hiz;
        logic blank;
        logic pol;
    } drv_ctrl_t;

    typedef enum logic [1:0] {
        DRV_OFF,
        DRV_CONST,
        DRV_TRUE,
        DRV_INV
    } drv_state_e;

    // Priority: release beats blanking, blanking beats data.
    function automatic drv_state_e drv_decode(drv_ctrl_t c);
        if (c.hiz)
            return DRV_OFF;
        else if (c.blank)
            return DRV_CONST;
        else if (c.pol)
            return DRV_TRUE;
        else
            return DRV_INV;
    endfunction

endpackage

// File: rtl/colshift_edge.sv
module colshift_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic evt
);
    logic sig_q;

    always_ff @(posedge clk) begin
        sig_q <= sig;
    end

    generate
        if (RISING) begin : g_rise
            assign evt = !rst && !sig_q && sig;
        end else begin : g_fall
            assign evt = !rst && sig_q && !sig;
        end
    endgenerate

endmodule

// File: rtl/colshift_chain.sv
module colshift_chain
    import colshift_pkg::*;
#(
    parameter int unsigned N_STAGES = 96,
    parameter int unsigned W_NARROW = 3,
    parameter int unsigned W_WIDE   = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_evt,
    input  shift_dir_e          dir,
    input  lane_mode_e          mode,
    input  logic [W_WIDE-1:0]   a_in,
    input  logic [W_WIDE-1:0]   b_in,
    output logic [W_WIDE-1:0]   a_out,
    output logic                a_oe,
    output logic [W_WIDE-1:0]   b_out,
    output logic                b_oe,
    output logic [N_STAGES-1:0] stages
);
    localparam int unsigned LO_N = N_STAGES - W_NARROW;
    localparam int unsigned LO_W = N_STAGES - W_WIDE;

    logic [N_STAGES-1:0] st_q;
    logic [N_STAGES-1:0] nxt_up;
    logic [N_STAGES-1:0] nxt_dn;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        logic up_n, up_w, dn_n, dn_w;
        if (i >= W_NARROW) begin : g_un
            assign up_n = st_q[i-W_NARROW];
        end else begin : g_un_in
            assign up_n = a_in[i];
        end
        if (i >= W_WIDE) begin : g_uw
            assign up_w = st_q[i-W_WIDE];
        end else begin : g_uw_in
            assign up_w = a_in[i];
        end
        if (i < LO_N) begin : g_dn
            assign dn_n = st_q[i+W_NARROW];
        end else begin : g_dn_in
            assign dn_n = b_in[i-LO_N];
        end
        if (i < LO_W) begin : g_dw
            assign dn_w = st_q[i+W_WIDE];
        end else begin : g_dw_in
            assign dn_w = b_in[i-LO_W];
        end
        assign nxt_up[i] = (mode == MODE_NARROW) ? up_n : up_w;
        assign nxt_dn[i] = (mode == MODE_NARROW) ? dn_n : dn_w;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else if (shift_evt)
            st_q <= (dir == DIR_FROM_A) ? nxt_up : nxt_dn;
    end

    always_comb begin
        a_out = '0;
        b_out = '0;
        if (dir == DIR_FROM_B) begin
            if (mode == MODE_NARROW)
                a_out[W_NARROW-1:0] = st_q[W_NARROW-1:0];
            else
                a_out = st_q[W_WIDE-1:0];
        end else begin
            if (mode == MODE_NARROW)
                b_out[W_NARROW-1:0] = st_q[N_STAGES-1 -: W_NARROW];
            else
                b_out = st_q[N_STAGES-1 -: W_WIDE];
        end
    end

    assign a_oe   = (dir == DIR_FROM_B);
    assign b_oe   = (dir == DIR_FROM_A);
    assign stages = st_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift_evt |=> $stable(st_q)); // R2
    AST_ENTRY_A: assert property (@(posedge clk) disable iff (rst)
        (shift_evt && dir == DIR_FROM_A) |=> st_q[W_NARROW-1:0] == $past(a_in[W_NARROW-1:0])); // R3
    AST_ENTRY_B: assert property (@(posedge clk) disable iff (rst)
        (shift_evt && dir == DIR_FROM_B && mode == MODE_NARROW)
        |=> st_q[N_STAGES-1 -: W_NARROW] == $past(b_in[W_NARROW-1:0])); // R4
    AST_WIDE_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (shift_evt && dir == DIR_FROM_A && mode == MODE_WIDE)
        |=> st_q[N_STAGES-1:W_WIDE] == $past(st_q[LO_W-1:0])); // R5
    AST_SPARE_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NARROW) |-> (a_out[W_WIDE-1:W_NARROW] == '0 && b_out[W_WIDE-1:W_NARROW] == '0)); // R6
    AST_IDLE_PORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        a_oe |-> b_out == '0); // R7

endmodule

// File: rtl/colshift_out.sv
module colshift_out
    import colshift_pkg::*;
#(
    parameter int unsigned N_STAGES = 96
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_evt,
    input  logic [N_STAGES-1:0] stages,
    input  drv_ctrl_t           ctrl,
    output logic [N_STAGES-1:0] drv_data,
    output logic                drv_drive
);
    logic [N_STAGES-1:0] lat_q;
    drv_state_e          state;

    always_ff @(posedge clk) begin
        if (rst)
            lat_q <= '0;
        else if (cap_evt)
            lat_q <= stages;
    end

    assign state = drv_decode(ctrl);

    always_comb begin
        drv_data  = '0;
        drv_drive = 1'b1;
        case (state)
            DRV_OFF:   drv_drive = 1'b0;
            DRV_CONST: drv_data  = {N_STAGES{ctrl.pol}};
            DRV_TRUE:  drv_data  = lat_q;
            DRV_INV:   drv_data  = ~lat_q;
            default:   drv_drive = 1'b0;
        endcase
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_evt |=> $stable(lat_q)); // R8
    AST_LATCH_TAKE: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> lat_q == $past(stages)); // R8
    AST_HIZ_FIRST: assert property (@(posedge clk) disable iff (rst)
        ctrl.hiz |-> (!drv_drive && drv_data == '0)); // R9
    AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.hiz && ctrl.blank) |-> (drv_drive && drv_data == {N_STAGES{ctrl.pol}})); // R10
    AST_POL_SENSE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.hiz && !ctrl.blank) |-> (drv_data[0] == (lat_q[0] ~^ ctrl.pol))); // R11

endmodule

// File: rtl/colshift_top.sv
module colshift_top
    import colshift_pkg::*;
#(
    parameter int unsigned N_STAGES = 96,
    parameter int unsigned W_NARROW = 3,
    parameter int unsigned W_WIDE   = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shclk,
    input  logic                dir,
    input  logic                lane_sel,
    input  logic [W_WIDE-1:0]   a_in,
    output logic [W_WIDE-1:0]   a_out,
    output logic                a_oe,
    input  logic [W_WIDE-1:0]   b_in,
    output logic [W_WIDE-1:0]   b_out,
    output logic                b_oe,
    input  logic                ld,
    input  logic                blank,
    input  logic                pol,
    input  logic                hiz,
    output logic [N_STAGES-1:0] drv_data,
    output logic                drv_drive
);
    logic                shift_evt;
    logic                cap_evt;
    logic [N_STAGES-1:0] stages;
    drv_ctrl_t           ctrl;

    assign ctrl = '{hiz: hiz, blank: blank, pol: pol};

    colshift_edge #(.RISING(1'b0)) u_shift_edge (
        .clk (clk), .rst (rst), .sig (shclk), .evt (shift_evt)
    );

    colshift_edge #(.RISING(1'b1)) u_load_edge (
        .clk (clk), .rst (rst), .sig (ld), .evt (cap_evt)
    );

    colshift_chain #(
        .N_STAGES (N_STAGES), .W_NARROW (W_NARROW), .W_WIDE (W_WIDE)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .shift_evt (shift_evt),
        .dir       (shift_dir_e'(dir)),
        .mode      (lane_mode_e'(lane_sel)),
        .a_in      (a_in),
        .b_in      (b_in),
        .a_out     (a_out),
        .a_oe      (a_oe),
        .b_out     (b_out),
        .b_oe      (b_oe),
        .stages    (stages)
    );

    colshift_out #(.N_STAGES (N_STAGES)) u_out (
        .clk       (clk),
        .rst       (rst),
        .cap_evt   (cap_evt),
        .stages    (stages),
        .ctrl      (ctrl),
        .drv_data  (drv_data),
        .drv_drive (drv_drive)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (a_out == '0 && b_out == '0)); // R1

endmodule

// File: tb/colshift_top_tb_top.sv
module colshift_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        shclk = 1'b0, dir = 1'b1, lane_sel = 1'b1;
    logic [5:0]  a_in = '0, b_in = '0;
    logic        ld = 1'b0, blank = 1'b0, pol = 1'b1, hiz = 1'b0;
    logic [5:0]  a_out, b_out;
    logic        a_oe, b_oe;
    logic [95:0] drv_data;
    logic        drv_drive;

    int n_chk = 0;
    int n_bad = 0;
    logic [95:0] mdl = '0;
    logic [95:0] lat_mdl = '0;

    // {hiz, blank, pol, kind}: kind 0 released, 1 ones, 2 zeros, 3 true, 4 inverted
    localparam logic [5:0] DRV_TAB [8] = '{
        6'b000_100, 6'b001_011, 6'b010_010, 6'b011_001,
        6'b100_000, 6'b101_000, 6'b110_000, 6'b111_000
    };

    always #5ns clk = ~clk;

    colshift_top dut_i (
        .clk (clk), .rst (rst), .shclk (shclk), .dir (dir), .lane_sel (lane_sel),
        .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_in), .b_out (b_out), .b_oe (b_oe),
        .ld (ld), .blank (blank), .pol (pol), .hiz (hiz),
        .drv_data (drv_data), .drv_drive (drv_drive)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mdl = '0;
        lat_mdl = '0;
    endtask

    task automatic model_shift(input logic [5:0] a, input logic [5:0] b);
        int w = lane_sel ? 3 : 6;
        logic [95:0] n;
        if (dir) begin
            n = mdl << w;
            for (int k = 0; k < w; k++) n[k] = a[k];
        end else begin
            n = mdl >> w;
            for (int k = 0; k < w; k++) n[96-w+k] = b[k];
        end
        mdl = n;
    endtask

    task automatic do_shift(input logic [5:0] a, input logic [5:0] b);
        @(negedge clk) shclk = 1'b1;
        @(negedge clk) begin a_in = a; b_in = b; shclk = 1'b0; end
        @(negedge clk);
        model_shift(a, b);
    endtask

    task automatic check_ports(input string req);
        int w = lane_sel ? 3 : 6;
        logic [5:0] ea = '0, eb = '0;
        for (int k = 0; k < w; k++) begin
            if (dir) eb[k] = mdl[96-w+k];
            else     ea[k] = mdl[k];
        end
        check({req, " a_out"}, {90'b0, a_out}, {90'b0, ea});
        check({req, " b_out"}, {90'b0, b_out}, {90'b0, eb});
    endtask

    task automatic do_latch();
        @(negedge clk) ld = 1'b1;
        @(negedge clk) ld = 1'b0;
        @(negedge clk);
        lat_mdl = mdl;
    endtask

    task automatic run_phase(input logic d, input logic nar, input int cnt, input int seed);
        @(negedge clk) begin dir = d; lane_sel = nar; end
        @(negedge clk);
        check("R7 a_oe", {95'b0, a_oe}, {95'b0, !d});
        check("R7 b_oe", {95'b0, b_oe}, {95'b0, d});
        for (int n = 0; n < cnt; n++) begin
            logic [5:0] a = 6'((n * 37 + seed) & 63);
            logic [5:0] b = 6'((n * 53 + seed * 7 + 11) & 63);
            do_shift(a, b);
            if (d) check_ports(nar ? "R3 R6 R7 A-to-B narrow" : "R3 R7 A-to-B wide");
            else   check_ports(nar ? "R4 R6 R7 B-to-A narrow" : "R4 R7 B-to-A wide");
        end
    endtask

    initial begin
        #1ms;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl = '0;
        @(negedge clk);
        // R1 reset state
        check("R1 drv_data", drv_data, 96'b0);
        check("R1 drv_drive", {95'b0, drv_drive}, 96'd1);
        check_ports("R1");
        check("R7 reset a_oe", {95'b0, a_oe}, 96'd0);
        check("R7 reset b_oe", {95'b0, b_oe}, 96'd1);

        // R5 depth, 3 lanes: word appears at B on shift 32
        @(negedge clk) begin dir = 1'b1; lane_sel = 1'b1; end
        do_shift(6'h07, 6'h00);
        for (int n = 2; n <= 31; n++) do_shift(6'h00, 6'h3f);
        check("R5 narrow before 32", {90'b0, b_out}, 96'd0);
        do_shift(6'h00, 6'h3f);
        check("R5 narrow at 32", {90'b0, b_out}, 96'h7);

        // R5 depth, 6 lanes: word appears at B on shift 16
        do_reset();
        @(negedge clk) lane_sel = 1'b0;
        do_shift(6'h3f, 6'h00);
        for (int n = 2; n <= 15; n++) do_shift(6'h00, 6'h3f);
        check("R5 wide before 16", {90'b0, b_out}, 96'd0);
        do_shift(6'h00, 6'h3f);
        check("R5 wide at 16", {90'b0, b_out}, 96'h3f);

        do_reset();
        run_phase(1'b1, 1'b1, 40, 5);

        // R2: a rise alone and a held level do not shift
        @(negedge clk) shclk = 1'b1;
        repeat (3) @(negedge clk);
        check_ports("R2 rise only");
        do_shift(6'h05, 6'h2a);
        repeat (4) @(negedge clk);
        check_ports("R2 held low");

        // R8 capture and hold
        do_latch();
        check("R8 capture", drv_data, lat_mdl);
        do_shift(6'h3f, 6'h00);
        do_shift(6'h12, 6'h00);
        check("R8 hold while shifting", drv_data, lat_mdl);
        @(negedge clk) ld = 1'b1;
        @(negedge clk);
        lat_mdl = mdl;
        do_shift(6'h2d, 6'h00);
        check("R8 ld held high", drv_data, lat_mdl);
        @(negedge clk) ld = 1'b0;
        @(negedge clk);
        check("R8 ld falling", drv_data, lat_mdl);

        // R9 R10 R11 output-stage truth table
        for (int t = 0; t < 8; t++) begin
            logic [95:0] exp_d;
            logic        exp_on;
            @(negedge clk) {hiz, blank, pol} = DRV_TAB[t][5:3];
            @(negedge clk);
            exp_on = 1'b1;
            case (DRV_TAB[t][2:0])
                3'd0:    begin exp_d = '0; exp_on = 1'b0; end
                3'd1:    exp_d = '1;
                3'd2:    exp_d = '0;
                3'd3:    exp_d = lat_mdl;
                default: exp_d = ~lat_mdl;
            endcase
            check(DRV_TAB[t][2:0] == 3'd0 ? "R9 data" :
                  DRV_TAB[t][2:0] <= 3'd2 ? "R10 data" : "R11 data", drv_data, exp_d);
            check("R9 drive", {95'b0, drv_drive}, {95'b0, exp_on});
        end
        @(negedge clk) {hiz, blank, pol} = 3'b001;

        run_phase(1'b0, 1'b0, 30, 9);
        run_phase(1'b0, 1'b1, 30, 21);
        run_phase(1'b1, 1'b0, 20, 3);
        do_latch();
        check("R8 capture after phases", drv_data, lat_mdl);
        @(negedge clk) pol = 1'b0;
        @(negedge clk);
        check("R11 inverted after phases", drv_data, ~lat_mdl);
        @(negedge clk) pol = 1'b1;

        // R1 reset in mid-run
        do_reset();
        @(negedge clk);
        check("R1 mid-run drv_data", drv_data, 96'b0);
        check_ports("R1 mid-run");

        report();
        $finish;
    end

endmodule